// File: doc/BRIEF.md
# Sector-Compressed Fully Associative Translation Buffer

This block is a small fully associative translation cache in which every entry stands for a sector of eight neighbouring virtual pages. The pages in a sector share one upper tag, one address-space ID, one set of upper physical page bits and one permission byte. Each page in the sector keeps its own valid bit and its own 3-bit low physical page field. A lookup presents a 27-bit virtual page number and a 16-bit address-space ID. On the following cycle the block answers with a hit and the translated 24-bit physical page number, or with a miss.

Entries come from page-walk results through a refill port. The refill port writes an entry into the lowest-numbered empty slot. When no slot is empty, it writes into the slot that a binary-tree pseudo-LRU selects. Entries may also describe 2 MB and 1 GB pages. For those, the tag compare narrows to the bits the page size leaves significant, and the low physical bits come from the lookup address. A lookup made in the same cycle as a refill already sees the new entry. A flush input empties the whole array in one cycle.

Top module: `tlbc_top`

## Requirements
- R1: `resp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. A hit or a miss is reported in that response cycle.
- R2: A lookup hits only if all three of these hold: the level-aware tag matches, the stored ID equals `req_asid`, and the sub-page valid bit selected by `req_vpn[2:0]` is set. Otherwise `resp_hit` is 0.
- R3: For a level-0 entry, `resp_ppn` = {upper 21 bits, low field k}, where k = `req_vpn[2:0]`. Low field k of a refill sits at `fill_ppn_lo[3k+2:3k]`.
- R4: Level 1 (2 MB) compares `vpn[26:9]`. Level 2 or 3 (1 GB) compares `vpn[26:18]`. A level-1 hit returns {`ppn_hi[20:6]`, `vpn[8:0]`}. A level-2 hit returns {`ppn_hi[20:15]`, `vpn[17:0]`}. A refill with a nonzero level sets all eight sub-page valid bits, whatever `fill_sub_valid` holds.
- R5: `resp_primary` is 1 on a hit whose `req_vpn[2:0]` equals the low three bits of the `fill_vpn` that created the entry.
- R6: A refill goes to the lowest-numbered slot whose eight valid bits are all 0, whenever such a slot exists. Hence the first ENTRIES distinct refills after reset or flush all stay resident.
- R7: With no empty slot, the victim follows a binary pseudo-LRU tree. Every hit and every refill turns each node on that slot's path away from it: a hit first, then a refill in the same cycle.
- R8: A lookup in the same cycle as a refill is answered against the array with that refill already written.
- R9: `flush` clears every valid bit and resets the tree. A lookup in the flush cycle misses, and a refill in the flush cycle is dropped.
- R10: During and after reset the array is empty and `resp_valid` is 0.
- R11: On a miss response, `resp_ppn`, `resp_perm`, `resp_level` and `resp_primary` are all 0.
- R12: A lookup whose address-space ID differs from the entry's misses, even when the tag matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | 27 | Lookup virtual page number |
| req_asid | input | 16 | Lookup address-space ID |
| fill_valid | input | 1 | Refill write |
| fill_vpn | input | 27 | Page number that caused the walk |
| fill_asid | input | 16 | Refill address-space ID |
| fill_level | input | 2 | 0 = 4 KB, 1 = 2 MB, 2/3 = 1 GB |
| fill_ppn_hi | input | 21 | Shared upper physical page bits |
| fill_ppn_lo | input | 24 | Eight 3-bit low physical fields |
| fill_sub_valid | input | 8 | Per-sub-page valid bits |
| fill_perm | input | 8 | Permission byte |
| flush | input | 1 | Empty the array |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Lookup hit |
| resp_ppn | output | 24 | Translated physical page number |
| resp_perm | output | 8 | Permission byte of hit entry |
| resp_level | output | 2 | Level of hit entry |
| resp_primary | output | 1 | Hit sub-page was the one originally walked |

## Verification
The assertions assume that no two resident entries ever cover the same page for the same ID, so at most one slot can hit. The page walker and its request filter guarantee this in a real system. The stimulus honours the same condition. It keeps the superpage, sector and random regions apart. In the random phase it issues a refill only when the bench model shows no resident entry for that page and ID. Apart from that, lookups, refills and flushes are free to land in the same cycle.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;

    localparam int VPN_W  = 27;
    localparam int SUB_W  = 3;
    localparam int SUB_N  = 1 << SUB_W;
    localparam int TAG_W  = VPN_W - SUB_W;
    localparam int PPN_W  = 24;
    localparam int PPNH_W = PPN_W - SUB_W;
    localparam int ASID_W = 16;
    localparam int LVL_W  = 2;
    localparam int PERM_W = 8;
    // page-number bits covered by one 2 MB and one 1 GB page
    localparam int SPAN_MID = 9;
    localparam int SPAN_BIG = 18;

    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [ASID_W-1:0] asid_t;
    typedef logic [PPN_W-1:0]  ppn_t;

    typedef enum logic [LVL_W-1:0] {
        PG_SMALL = 2'd0,
        PG_MID   = 2'd1,
        PG_BIG   = 2'd2,
        PG_BIG_X = 2'd3
    } pg_level_e;

    typedef struct packed {
        logic [TAG_W-1:0]            tag;
        asid_t                       asid;
        pg_level_e                   level;
        logic [PPNH_W-1:0]           ppn_hi;
        logic [SUB_N-1:0][SUB_W-1:0] ppn_lo;
        logic [SUB_N-1:0]            vld;
        logic [SUB_N-1:0]            orig;
        logic [PERM_W-1:0]           perm;
    } entry_t;

    function automatic logic entry_hit(entry_t e, vpn_t v, asid_t a);
        logic tag_ok;
        case (e.level)
            PG_SMALL: tag_ok = (e.tag == v[VPN_W-1:SUB_W]);
            PG_MID:   tag_ok = (e.tag[TAG_W-1:SPAN_MID-SUB_W] == v[VPN_W-1:SPAN_MID]);
            default:  tag_ok = (e.tag[TAG_W-1:SPAN_BIG-SUB_W] == v[VPN_W-1:SPAN_BIG]);
        endcase
        return tag_ok && (e.asid == a) && e.vld[v[SUB_W-1:0]];
    endfunction

    function automatic ppn_t entry_ppn(entry_t e, vpn_t v);
        case (e.level)
            PG_SMALL: return {e.ppn_hi, e.ppn_lo[v[SUB_W-1:0]]};
            PG_MID:   return {e.ppn_hi[PPNH_W-1:SPAN_MID-SUB_W], v[SPAN_MID-1:0]};
            default:  return {e.ppn_hi[PPNH_W-1:SPAN_BIG-SUB_W], v[SPAN_BIG-1:0]};
        endcase
    endfunction

    function automatic entry_t make_entry(vpn_t v, asid_t a, logic [LVL_W-1:0] lvl,
                                          logic [PPNH_W-1:0] hi,
                                          logic [SUB_N*SUB_W-1:0] lo,
                                          logic [SUB_N-1:0] sv,
                                          logic [PERM_W-1:0] pm);
        entry_t e;
        e.tag    = v[VPN_W-1:SUB_W];
        e.asid   = a;
        e.level  = pg_level_e'(lvl);
        e.ppn_hi = hi;
        e.ppn_lo = lo;
        e.vld    = (lvl != 2'd0) ? {SUB_N{1'b1}} : sv;
        e.orig   = SUB_N'(1) << v[SUB_W-1:0];
        e.perm   = pm;
        return e;
    endfunction

endpackage

// File: rtl/tlbc_plru.sv
module tlbc_plru #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int TN = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_way,
    output logic [IDX_W-1:0] victim
);

    logic [TN-2:0] tree_q, tree_d;

    function automatic logic [TN-2:0] touch(logic [TN-2:0] t, logic [IDX_W-1:0] w);
        int leaf;
        int node;
        int dir;
        leaf = int'(w) + TN;
        for (int l = 0; l < IDX_W; l++) begin
            node = leaf >> (IDX_W - l);
            dir  = (leaf >> (IDX_W - l - 1)) & 1;
            t[node-1] = (dir == 0);
        end
        return t;
    endfunction

    always_comb begin
        tree_d = tree_q;
        if (hit_en)  tree_d = touch(tree_d, hit_way);
        if (fill_en) tree_d = touch(tree_d, fill_way);
    end

    // walk from the root; a branch whose subtree holds no real slot is refused
    always_comb begin
        int node;
        int c;
        int base;
        node = 1;
        for (int l = 0; l < IDX_W; l++) begin
            c    = node * 2 + int'(tree_q[node-1]);
            base = (c - (1 << (l + 1))) << (IDX_W - l - 1);
            if (base >= N) c = node * 2;
            node = c;
        end
        victim = IDX_W'(node - TN);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) tree_q <= '0;
        else              tree_q <= tree_d;
    end

    AST_TREE_RESET_ON_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flush |=> (victim == '0)); // R9

    generate
        if (N == TN) begin : g_pow2
            AST_FILL_NOT_NEXT_VICTIM: assert property (@(posedge clk) disable iff (rst)
                (fill_en && !flush) |=> (victim != $past(fill_way))); // R7
        end
    endgenerate

endmodule

// File: rtl/tlbc_array.sv
module tlbc_array
    import tlbc_pkg::*;
#(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_way,
    input  entry_t           wr_entry,
    output entry_t           view [N],
    output logic [N-1:0]     free_vec
);

    entry_t ent_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < N; i++) ent_q[i].vld <= '0;
        end else if (wr_en) begin
            ent_q[wr_way] <= wr_entry;
        end
    end

    // lookup view: refill written through, flush empties it
    always_comb begin
        for (int i = 0; i < N; i++) begin
            view[i] = ent_q[i];
            if (wr_en && (wr_way == IDX_W'(i))) view[i] = wr_entry;
            if (flush) view[i].vld = '0;
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_free
            assign free_vec[g] = ~|ent_q[g].vld;
        end
    endgenerate

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (&free_vec)); // R9

    AST_SUPER_ALL_SUB: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush && (wr_entry.level != PG_SMALL))
            |=> (ent_q[$past(wr_way)].vld == {SUB_N{1'b1}})); // R4

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> !free_vec[$past(wr_way)] || ($past(wr_entry.vld) == '0)); // R6

endmodule

// File: rtl/tlbc_match.sv
module tlbc_match
    import tlbc_pkg::*;
#(
    parameter int N = 16
) (
    input  entry_t       view [N],
    input  vpn_t         vpn,
    input  asid_t        asid,
    output logic [N-1:0] hit_vec
);

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign hit_vec[g] = entry_hit(view[g], vpn, asid);
        end
    endgenerate

endmodule

// File: rtl/tlbc_top.sv
module tlbc_top
    import tlbc_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [VPN_W-1:0]        req_vpn,
    input  logic [ASID_W-1:0]       req_asid,
    input  logic                    fill_valid,
    input  logic [VPN_W-1:0]        fill_vpn,
    input  logic [ASID_W-1:0]       fill_asid,
    input  logic [LVL_W-1:0]        fill_level,
    input  logic [PPNH_W-1:0]       fill_ppn_hi,
    input  logic [SUB_N*SUB_W-1:0]  fill_ppn_lo,
    input  logic [SUB_N-1:0]        fill_sub_valid,
    input  logic [PERM_W-1:0]       fill_perm,
    input  logic                    flush,
    output logic                    resp_valid,
    output logic                    resp_hit,
    output logic [PPN_W-1:0]        resp_ppn,
    output logic [PERM_W-1:0]       resp_perm,
    output logic [LVL_W-1:0]        resp_level,
    output logic                    resp_primary
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    entry_t             view [ENTRIES];
    entry_t             fill_entry;
    entry_t             sel;
    logic [ENTRIES-1:0] free_vec;
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   plru_way;
    logic [IDX_W-1:0]   fill_way;
    logic [IDX_W-1:0]   hit_way;
    logic               fill_en;
    logic               hit_en;

    assign fill_en    = fill_valid & ~flush;
    assign fill_entry = make_entry(fill_vpn, fill_asid, fill_level, fill_ppn_hi,
                                   fill_ppn_lo, fill_sub_valid, fill_perm);

    // empty slots first, lowest index wins
    always_comb begin
        fill_way = plru_way;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) fill_way = IDX_W'(i);
        end
    end

    always_comb begin
        hit_way = '0;
        sel     = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_way = IDX_W'(i);
                sel     = view[i];
            end
        end
    end

    assign hit_en = req_valid & (|hit_vec);

    tlbc_array #(.N(ENTRIES)) u_array (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (fill_en),
        .wr_way   (fill_way),
        .wr_entry (fill_entry),
        .view     (view),
        .free_vec (free_vec)
    );

    tlbc_match #(.N(ENTRIES)) u_match (
        .view    (view),
        .vpn     (req_vpn),
        .asid    (req_asid),
        .hit_vec (hit_vec)
    );

    tlbc_plru #(.N(ENTRIES)) u_plru (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .hit_en   (hit_en),
        .hit_way  (hit_way),
        .fill_en  (fill_en),
        .fill_way (fill_way),
        .victim   (plru_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid   <= 1'b0;
            resp_hit     <= 1'b0;
            resp_ppn     <= '0;
            resp_perm    <= '0;
            resp_level   <= '0;
            resp_primary <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                resp_hit     <= |hit_vec;
                resp_ppn     <= hit_en ? entry_ppn(sel, req_vpn) : '0;
                resp_perm    <= hit_en ? sel.perm : '0;
                resp_level   <= hit_en ? sel.level : '0;
                resp_primary <= hit_en & sel.orig[req_vpn[SUB_W-1:0]];
            end
        end
    end

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R2

    AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid); // R1

    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid); // R1

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> (resp_ppn == '0 && resp_perm == '0
                                       && resp_level == '0 && !resp_primary)); // R11

    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (rst)
        (flush && req_valid) |=> !resp_hit); // R9

endmodule

// File: tb/tlbc_top_test.sv
module tlbc_top_test;

    localparam int N = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // driven inputs
    logic        d_req = 0, d_fill = 0, d_flush = 0;
    logic [26:0] d_vpn = 0, d_fvpn = 0;
    logic [15:0] d_asid = 0, d_fasid = 0;
    logic [1:0]  d_flvl = 0;
    logic [20:0] d_fph = 0;
    logic [23:0] d_fpl = 0;
    logic [7:0]  d_fsv = 0, d_fperm = 0;

    logic        resp_valid, resp_hit, resp_primary;
    logic [23:0] resp_ppn;
    logic [7:0]  resp_perm;
    logic [1:0]  resp_level;

    tlbc_top #(.ENTRIES(N)) uut (
        .clk(clk), .rst(rst),
        .req_valid(d_req), .req_vpn(d_vpn), .req_asid(d_asid),
        .fill_valid(d_fill), .fill_vpn(d_fvpn), .fill_asid(d_fasid),
        .fill_level(d_flvl), .fill_ppn_hi(d_fph), .fill_ppn_lo(d_fpl),
        .fill_sub_valid(d_fsv), .fill_perm(d_fperm), .flush(d_flush),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_ppn(resp_ppn),
        .resp_perm(resp_perm), .resp_level(resp_level), .resp_primary(resp_primary)
    );

    // next-cycle stimulus
    logic        s_req, s_fill, s_flush;
    logic [26:0] s_vpn, s_fvpn;
    logic [15:0] s_asid, s_fasid;
    logic [1:0]  s_flvl;
    logic [20:0] s_fph;
    logic [23:0] s_fpl;
    logic [7:0]  s_fsv, s_fperm;
    string       s_tag;

    // behavioural model state
    logic [26:0] m_vpn [N];
    logic [15:0] m_asid [N];
    logic [1:0]  m_lvl [N];
    logic [20:0] m_ph [N];
    logic [23:0] m_pl [N];
    logic [7:0]  m_sv [N], m_pm [N];
    bit          m_tree [1:N-1];

    // expected response
    logic        e_valid = 0, e_hit = 0, e_prim = 0;
    logic [23:0] e_ppn = 0;
    logic [7:0]  e_perm = 0;
    logic [1:0]  e_lvl = 0;
    string       e_tag = "R1";

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic clear_stim();
        s_req = 0; s_fill = 0; s_flush = 0; s_vpn = 0; s_fvpn = 0; s_asid = 0;
        s_fasid = 0; s_flvl = 0; s_fph = 0; s_fpl = 0; s_fsv = 0; s_fperm = 0;
        s_tag = "R2";
    endtask

    function automatic int span(logic [1:0] l);
        return (l == 0) ? 3 : (l == 1) ? 9 : 18;
    endfunction

    task automatic touch(int w);
        int node = 1;
        for (int l = 3; l >= 0; l--) begin
            int b = (w >> l) & 1;
            m_tree[node] = (b == 0);
            node = node * 2 + b;
        end
    endtask

    task automatic compare_out();
        chk("R1", "resp_valid", 32'(resp_valid), 32'(e_valid));
        if (e_valid && resp_valid) begin
            chk(e_tag, "resp_hit", 32'(resp_hit), 32'(e_hit));
            chk(e_hit ? e_tag : "R11", "resp_ppn", 32'(resp_ppn), 32'(e_ppn));
            chk(e_hit ? e_tag : "R11", "resp_perm", 32'(resp_perm), 32'(e_perm));
            chk(e_hit ? "R4" : "R11", "resp_level", 32'(resp_level), 32'(e_lvl));
            chk(e_hit ? "R5" : "R11", "resp_primary", 32'(resp_primary), 32'(e_prim));
        end
    endtask

    task automatic tick();
        int vic, node;
        bit fe, h;
        logic [7:0] nsv;
        @(negedge clk);
        compare_out();
        d_req = s_req; d_vpn = s_vpn; d_asid = s_asid; d_fill = s_fill; d_fvpn = s_fvpn;
        d_fasid = s_fasid; d_flvl = s_flvl; d_fph = s_fph; d_fpl = s_fpl; d_fsv = s_fsv;
        d_fperm = s_fperm; d_flush = s_flush;
        fe  = s_fill && !s_flush;
        nsv = (s_flvl != 0) ? 8'hFF : s_fsv;
        vic = -1;
        for (int i = 0; i < N; i++) if (m_sv[i] == 0 && vic < 0) vic = i;
        if (vic < 0) begin
            node = 1;
            repeat (4) node = node * 2 + int'(m_tree[node]);
            vic = node - N;
        end
        h = 0; e_ppn = 0; e_perm = 0; e_lvl = 0; e_prim = 0;
        if (s_req && !s_flush) begin
            for (int i = 0; i < N; i++) begin
                bit byp = fe && (i == vic);
                logic [26:0] ev = byp ? s_fvpn : m_vpn[i];
                logic [15:0] ea = byp ? s_fasid : m_asid[i];
                logic [1:0]  el = byp ? s_flvl : m_lvl[i];
                logic [20:0] eh = byp ? s_fph : m_ph[i];
                logic [23:0] eo = byp ? s_fpl : m_pl[i];
                logic [7:0]  es = byp ? nsv : m_sv[i];
                logic [7:0]  ep = byp ? s_fperm : m_pm[i];
                int sh = span(el);
                if (es[s_vpn[2:0]] && ea == s_asid && ((ev >> sh) == (s_vpn >> sh))) begin
                    logic [23:0] msk = 24'((1 << sh) - 1);
                    h = 1;
                    if (el == 0) e_ppn = {eh, eo[3*s_vpn[2:0] +: 3]};
                    else e_ppn = ({eh, 3'b000} & ~msk) | (s_vpn[23:0] & msk);
                    e_perm = ep; e_lvl = el; e_prim = (ev[2:0] == s_vpn[2:0]);
                    if (!byp) touch(i); else touch(vic);
                end
            end
        end
        e_valid = s_req; e_hit = h; e_tag = s_tag;
        if (s_flush) begin
            for (int i = 0; i < N; i++) m_sv[i] = 0;
            for (int i = 1; i < N; i++) m_tree[i] = 0;
        end else if (fe) begin
            m_vpn[vic] = s_fvpn; m_asid[vic] = s_fasid; m_lvl[vic] = s_flvl;
            m_ph[vic] = s_fph; m_pl[vic] = s_fpl; m_sv[vic] = nsv; m_pm[vic] = s_fperm;
            touch(vic);
        end
        clear_stim();
    endtask

    task automatic lk(logic [26:0] v, logic [15:0] a, string t);
        s_req = 1; s_vpn = v; s_asid = a; s_tag = t;
        tick();
    endtask

    task automatic set_fill(logic [26:0] v, logic [15:0] a, logic [1:0] l, logic [20:0] ph,
                            logic [23:0] pl, logic [7:0] sv, logic [7:0] pm);
        s_fill = 1; s_fvpn = v; s_fasid = a; s_flvl = l; s_fph = ph; s_fpl = pl;
        s_fsv = sv; s_fperm = pm;
    endtask

    function automatic bit resident(logic [26:0] v, logic [15:0] a);
        for (int i = 0; i < N; i++)
            if (m_sv[i] != 0 && m_asid[i] == a && (m_vpn[i] >> 3) == (v >> 3)) return 1;
        return 0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_stim();
        for (int i = 0; i < N; i++) begin
            m_sv[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_lvl[i] = 0;
            m_ph[i] = 0; m_pl[i] = 0; m_pm[i] = 0;
        end
        for (int i = 1; i < N; i++) m_tree[i] = 0;
        repeat (3) begin
            @(negedge clk);
            chk("R10", "resp_valid in reset", 32'(resp_valid), 32'd0);
        end
        rst = 0;

        lk(27'h0000154, 16'd5, "R10");
        // sector refill: low field k = k+1, sub-pages 0,2,4,5 valid
        set_fill(27'h0000154, 16'd5, 2'd0, 21'h12345,
                 {3'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1}, 8'b0011_0101, 8'hA5);
        tick();
        lk(27'h0000154, 16'd5, "R3");
        lk(27'h0000150, 16'd5, "R5");
        lk(27'h0000152, 16'd5, "R3");
        lk(27'h0000151, 16'd5, "R2");
        lk(27'h000015C, 16'd5, "R2");
        lk(27'h0000154, 16'd6, "R12");

        set_fill(27'h0123456, 16'd5, 2'd1, 21'h1ABCD, 24'h0, 8'h00, 8'h3C);
        tick();
        lk(27'h0123401, 16'd5, "R4");
        lk(27'h01235FF, 16'd5, "R4");
        lk(27'h0123656, 16'd5, "R4");
        set_fill(27'h2A00000, 16'd7, 2'd2, 21'h155555, 24'hFFFFFF, 8'h10, 8'h0F);
        tick();
        lk(27'h2A3FFFF, 16'd7, "R4");
        lk(27'h2A40000, 16'd7, "R4");

        // lookup meets refill of the same page in one cycle
        s_req = 1; s_vpn = 27'h0000777; s_asid = 16'd5; s_tag = "R8";
        set_fill(27'h0000777, 16'd5, 2'd0, 21'h0F0F0, 24'h123456, 8'h80, 8'h77);
        tick();

        for (int i = 0; i < 12; i++) begin
            set_fill(27'h1000000 + 27'(i * 8), 16'd9, 2'd0, 21'(i * 3), 24'(i * 11), 8'hFF, 8'(i));
            tick();
        end
        lk(27'h0000154, 16'd5, "R6");
        lk(27'h0123400, 16'd5, "R6");
        lk(27'h2A00001, 16'd7, "R6");
        lk(27'h0000777, 16'd5, "R6");
        for (int i = 0; i < 12; i++) lk(27'h1000003 + 27'(i * 8), 16'd9, "R6");
        lk(27'h1000010, 16'd9, "R7");
        lk(27'h1000048, 16'd9, "R7");
        for (int i = 0; i < 4; i++) begin
            set_fill(27'h1800000 + 27'(i * 8), 16'd9, 2'd0, 21'h0AAAA, 24'h0, 8'hFF, 8'h55);
            tick();
        end
        for (int i = 0; i < 12; i++) lk(27'h1000001 + 27'(i * 8), 16'd9, "R7");
        for (int i = 0; i < 4; i++) lk(27'h1800002 + 27'(i * 8), 16'd9, "R7");
        lk(27'h0000154, 16'd5, "R7");
        lk(27'h0123400, 16'd5, "R7");

        s_flush = 1; s_req = 1; s_vpn = 27'h0000154; s_asid = 16'd5; s_tag = "R9";
        set_fill(27'h1900000, 16'd9, 2'd0, 21'h1, 24'h0, 8'hFF, 8'h1);
        tick();
        lk(27'h0000154, 16'd5, "R9");
        lk(27'h1900000, 16'd9, "R9");
        lk(27'h2A00000, 16'd7, "R9");

        for (int c = 0; c < 4000; c++) begin
            logic [26:0] rv = 27'h0200000 + 27'(($urandom % 24) * 8) + 27'($urandom % 8);
            logic [15:0] ra = 16'(1 + ($urandom % 2));
            if (($urandom % 4) != 0) begin
                s_req = 1; s_vpn = rv; s_asid = ra; s_tag = "R7";
            end
            if (($urandom % 4) == 0) begin
                logic [26:0] fv = 27'h0200000 + 27'(($urandom % 24) * 8) + 27'($urandom % 8);
                logic [15:0] fa = 16'(1 + ($urandom % 2));
                if (!resident(fv, fa))
                    set_fill(fv, fa, 2'd0, 21'($urandom), 24'($urandom),
                             8'($urandom) | (8'd1 << fv[2:0]), 8'($urandom));
            end
            if (($urandom % 300) == 0) s_flush = 1;
            tick();
        end
        tick();
        tick();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule